// File: doc/BRIEF.md
# Fully Associative Translation Cache with Address-Space Tags

This block caches page-to-frame translations for a processor's memory-management path. It has a fixed set of entries. Each entry holds a virtual page number, the address-space identifier of the process that owns the translation, and a physical frame number. A lookup presents a page number together with the identifier of the running process. The block compares that pair against every entry in parallel and returns hit and frame number combinationally, in the same cycle. On a miss, the page-table walker elsewhere in the chip fetches the translation and writes it back through the fill port.

Each entry is a small state machine with three states. `ENT_FREE` holds no translation. `ENT_LIVE` holds a translation that may be replaced. `ENT_WIRED` holds a translation that replacement never touches. The transitions are:
- fill (FREE→LIVE, or FREE→WIRED when the fill asks to be wired)
- replace (LIVE→LIVE or LIVE→WIRED with new contents)
- pin (LIVE→WIRED)
- unpin (WIRED→LIVE)
- flush (LIVE→FREE)

A fill goes to the lowest-numbered free entry. When no entry is free, the fill goes to the first non-wired entry at or after a rotating pointer. A global flush clears every entry that is not wired. A per-identifier flush clears only the non-wired entries of one process. Both complete in one cycle.

Top module: `tlb_fa_asid`

## Requirements
- R1: After reset every entry is free: every lookup misses, and the first fill is placed in entry 0.
- R2: With `lk_valid`=1, `lk_hit` is 1 in the same cycle when a non-free entry matches both `lk_vpn` and `lk_asid`, and `lk_pfn` then carries that entry's frame. With `lk_valid`=0, `lk_hit` is 0.
- R3: An entry whose page matches but whose identifier differs from `lk_asid` does not hit.
- R4: While any entry is free, an accepted fill goes to the lowest-numbered free entry, and `fill_slot` shows that index in the fill cycle.
- R5: When no entry is free, the fill replaces the first non-wired entry found by counting upward from a pointer that starts at 0 after reset. After such a replacement the pointer moves to the entry after the victim, wrapping from the last entry to 0. Fills into free entries leave the pointer unchanged.
- R6: A wired entry is never chosen for replacement. A fill while every entry is wired raises `fill_reject` in that cycle and changes no entry.
- R7: `pin_en` with `pin_set`=1 moves the non-free entry `pin_idx` to wired. With `pin_set`=0 it moves the entry back to replaceable. Pinning a free entry has no effect.
- R8: `flush_all` frees every non-wired entry in one cycle. Wired entries keep their translations.
- R9: `flush_asid_en` frees only the non-wired entries whose identifier equals `flush_asid`.
- R10: A fill in a cycle with either flush request is dropped and `fill_reject` is 1.
- R11: A lookup in the same cycle as a fill sees the table as it was before that fill. The new translation hits from the next cycle on.
- R12: A fill with `fill_wire`=1 installs the entry directly as wired, so a later global flush keeps it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Page number to translate |
| lk_asid | input | ASID_W | Identifier of the running process |
| lk_hit | output | 1 | Lookup matched an entry |
| lk_pfn | output | PFN_W | Frame number of the matching entry |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Page number to install |
| fill_asid | input | ASID_W | Owner identifier to install |
| fill_pfn | input | PFN_W | Frame number to install |
| fill_wire | input | 1 | Install the entry as wired |
| fill_reject | output | 1 | Fill could not be placed |
| fill_slot | output | IDX_W | Entry chosen for the fill |
| pin_en | input | 1 | Change the wired status of one entry |
| pin_idx | input | IDX_W | Entry whose status changes |
| pin_set | input | 1 | 1 = wire, 0 = release |
| flush_all | input | 1 | Free all non-wired entries |
| flush_asid_en | input | 1 | Free non-wired entries of one identifier |
| flush_asid | input | ASID_W | Identifier for the selective flush |

## Verification
Lookups are tried with a matching page and identifier, a matching page under another identifier, and a matching page with the request line low. Together these separate the page compare, the identifier compare and the request qualifier. Fill sequences cover a table with free entries, a full table with the pointer at several positions, and a table with a wired entry in the pointer's path. Together they separate free-first placement from rotation, and show that wired entries are skipped. Flushes cover global and per-identifier clears over a mix of owners and wired entries, plus a flush that collides with a fill. A final run wires every entry to reach the rejection case and then releases one entry to reopen it.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [1:0] {
        ENT_FREE  = 2'd0,
        ENT_LIVE  = 2'd1,
        ENT_WIRED = 2'd2
    } ent_state_e;
endpackage

// File: rtl/tlb_entry.sv
module tlb_entry
    import tlb_pkg::*;
#(
    parameter int VPN_W  = 20,
    parameter int PFN_W  = 16,
    parameter int ASID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_sel,
    input  logic              fill_wire,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic              pin_sel,
    input  logic              pin_set,
    input  logic              flush_all,
    input  logic              flush_asid_en,
    input  logic [ASID_W-1:0] flush_asid,
    output ent_state_e        st,
    output logic [VPN_W-1:0]  vpn_q,
    output logic [ASID_W-1:0] asid_q,
    output logic [PFN_W-1:0]  pfn_q
);
    ent_state_e st_nxt;
    logic       flush_hit;

    assign flush_hit = flush_all | (flush_asid_en & (asid_q == flush_asid));

    // next-state logic
    always_comb begin
        st_nxt = st;
        unique case (st)
            ENT_FREE: begin
                if (fill_sel) st_nxt = fill_wire ? ENT_WIRED : ENT_LIVE;
            end
            ENT_LIVE: begin
                if (flush_hit)                 st_nxt = ENT_FREE;
                else if (fill_sel)             st_nxt = fill_wire ? ENT_WIRED : ENT_LIVE;
                else if (pin_sel && pin_set)   st_nxt = ENT_WIRED;
            end
            ENT_WIRED: begin
                if (pin_sel && !pin_set)       st_nxt = ENT_LIVE;
            end
            default: st_nxt = ENT_FREE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ENT_FREE;
        else        st <= st_nxt;
    end

    // entry contents
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q  <= '0;
            asid_q <= '0;
            pfn_q  <= '0;
        end else if (fill_sel) begin
            vpn_q  <= fill_vpn;
            asid_q <= fill_asid;
            pfn_q  <= fill_pfn;
        end
    end

    p_flush_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_all && st != ENT_WIRED) |=> (st == ENT_FREE));

    p_wired_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ENT_WIRED && !(pin_sel && !pin_set)) |=> (st == ENT_WIRED));
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] free_vec,
    input  logic [ENTRIES-1:0] wired_vec,
    input  logic               advance,
    output logic [IDX_W-1:0]   vic_idx,
    output logic               vic_ok,
    output logic               vic_free
);
    logic [IDX_W-1:0] rr;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] rot_idx;
    logic             free_found;
    logic             rot_found;

    function automatic logic [IDX_W-1:0] wrap(input logic [IDX_W-1:0] base, input int off);
        int s;
        s = int'(base) + off;
        if (s >= ENTRIES) s = s - ENTRIES;
        return IDX_W'(s);
    endfunction

    // lowest free entry
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    // first non-wired entry at or after the pointer
    always_comb begin
        rot_found = 1'b0;
        rot_idx   = '0;
        for (int k = ENTRIES - 1; k >= 0; k--) begin
            if (!wired_vec[wrap(rr, k)]) begin
                rot_found = 1'b1;
                rot_idx   = wrap(rr, k);
            end
        end
    end

    assign vic_free = free_found;
    assign vic_ok   = free_found | rot_found;
    assign vic_idx  = free_found ? free_idx : rot_idx;

    always_ff @(posedge clk) begin
        if (!rst_n)
            rr <= '0;
        else if (advance)
            rr <= (vic_idx == IDX_W'(ENTRIES - 1)) ? '0 : vic_idx + 1'b1;
    end

    p_no_wired_victim_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vic_ok |-> !wired_vec[vic_idx]);

    p_free_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|free_vec) |-> (vic_free && free_vec[vic_idx]));
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 16,
    parameter int ASID_W  = 8
) (
    input  logic                           lk_valid,
    input  logic [VPN_W-1:0]               lk_vpn,
    input  logic [ASID_W-1:0]              lk_asid,
    input  logic [ENTRIES-1:0]             used_vec,
    input  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_arr,
    input  logic [ENTRIES-1:0][ASID_W-1:0] asid_arr,
    input  logic [ENTRIES-1:0][PFN_W-1:0]  pfn_arr,
    output logic                           hit,
    output logic [PFN_W-1:0]               pfn
);
    logic [ENTRIES-1:0] hit_vec;

    always_comb begin
        pfn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            hit_vec[i] = lk_valid & used_vec[i] &
                         (vpn_arr[i] == lk_vpn) & (asid_arr[i] == lk_asid);
            pfn = pfn | ({PFN_W{hit_vec[i]}} & pfn_arr[i]);
        end
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/tlb_fa_asid.sv
module tlb_fa_asid
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 16,
    parameter int ASID_W  = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic [PFN_W-1:0]  lk_pfn,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic              fill_wire,
    output logic              fill_reject,
    output logic [IDX_W-1:0]  fill_slot,
    input  logic              pin_en,
    input  logic [IDX_W-1:0]  pin_idx,
    input  logic              pin_set,
    input  logic              flush_all,
    input  logic              flush_asid_en,
    input  logic [ASID_W-1:0] flush_asid
);
    ent_state_e                     st_vec [ENTRIES];
    logic [ENTRIES-1:0][VPN_W-1:0]  vpn_arr;
    logic [ENTRIES-1:0][ASID_W-1:0] asid_arr;
    logic [ENTRIES-1:0][PFN_W-1:0]  pfn_arr;
    logic [ENTRIES-1:0]             free_vec;
    logic [ENTRIES-1:0]             wired_vec;
    logic [ENTRIES-1:0]             used_vec;
    logic [IDX_W-1:0]               vic_idx;
    logic                           vic_ok;
    logic                           vic_free;
    logic                           flush_any;
    logic                           fill_go;
    logic                           pin_go;

    assign flush_any   = flush_all | flush_asid_en;
    assign fill_go     = fill_en & ~flush_any & vic_ok;
    assign fill_reject = fill_en & ~fill_go;
    assign fill_slot   = vic_idx;
    assign pin_go      = pin_en & ~flush_any & ~fill_en;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        tlb_entry #(
            .VPN_W (VPN_W),
            .PFN_W (PFN_W),
            .ASID_W(ASID_W)
        ) ent_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .fill_sel     (fill_go && (vic_idx == IDX_W'(g))),
            .fill_wire    (fill_wire),
            .fill_vpn     (fill_vpn),
            .fill_asid    (fill_asid),
            .fill_pfn     (fill_pfn),
            .pin_sel      (pin_go && (pin_idx == IDX_W'(g))),
            .pin_set      (pin_set),
            .flush_all    (flush_all),
            .flush_asid_en(flush_asid_en),
            .flush_asid   (flush_asid),
            .st           (st_vec[g]),
            .vpn_q        (vpn_arr[g]),
            .asid_q       (asid_arr[g]),
            .pfn_q        (pfn_arr[g])
        );
        assign free_vec[g]  = (st_vec[g] == ENT_FREE);
        assign wired_vec[g] = (st_vec[g] == ENT_WIRED);
        assign used_vec[g]  = (st_vec[g] != ENT_FREE);
    end

    tlb_victim #(
        .ENTRIES(ENTRIES),
        .IDX_W  (IDX_W)
    ) vic_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .free_vec (free_vec),
        .wired_vec(wired_vec),
        .advance  (fill_go & ~vic_free),
        .vic_idx  (vic_idx),
        .vic_ok   (vic_ok),
        .vic_free (vic_free)
    );

    tlb_match #(
        .ENTRIES(ENTRIES),
        .VPN_W  (VPN_W),
        .PFN_W  (PFN_W),
        .ASID_W (ASID_W)
    ) match_i (
        .lk_valid(lk_valid),
        .lk_vpn  (lk_vpn),
        .lk_asid (lk_asid),
        .used_vec(used_vec),
        .vpn_arr (vpn_arr),
        .asid_arr(asid_arr),
        .pfn_arr (pfn_arr),
        .hit     (lk_hit),
        .pfn     (lk_pfn)
    );

    p_fill_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !fill_reject) |=> (st_vec[$past(fill_slot)] != ENT_FREE));

    p_reject_all_wired_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_reject && !flush_any) |-> (&wired_vec));
endmodule

// File: tb/tlb_fa_asid_tb_top.sv
module tlb_fa_asid_tb_top;
    localparam int ENTRIES = 16;
    localparam int VPN_W   = 20;
    localparam int PFN_W   = 16;
    localparam int ASID_W  = 8;
    localparam int IDX_W   = $clog2(ENTRIES);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lk_valid = 1'b0;
    logic [VPN_W-1:0]  lk_vpn = '0;
    logic [ASID_W-1:0] lk_asid = '0;
    logic              lk_hit;
    logic [PFN_W-1:0]  lk_pfn;
    logic              fill_en = 1'b0;
    logic [VPN_W-1:0]  fill_vpn = '0;
    logic [ASID_W-1:0] fill_asid = '0;
    logic [PFN_W-1:0]  fill_pfn = '0;
    logic              fill_wire = 1'b0;
    logic              fill_reject;
    logic [IDX_W-1:0]  fill_slot;
    logic              pin_en = 1'b0;
    logic [IDX_W-1:0]  pin_idx = '0;
    logic              pin_set = 1'b0;
    logic              flush_all = 1'b0;
    logic              flush_asid_en = 1'b0;
    logic [ASID_W-1:0] flush_asid = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    tlb_fa_asid #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
        .lk_hit(lk_hit), .lk_pfn(lk_pfn),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
        .fill_pfn(fill_pfn), .fill_wire(fill_wire),
        .fill_reject(fill_reject), .fill_slot(fill_slot),
        .pin_en(pin_en), .pin_idx(pin_idx), .pin_set(pin_set),
        .flush_all(flush_all), .flush_asid_en(flush_asid_en),
        .flush_asid(flush_asid)
    );

    function automatic logic [PFN_W-1:0] pf(input int v);
        return 16'hA000 + PFN_W'(v);
    endfunction

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic lookup(input int v, input int a, input bit exp_hit, input string req);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_vpn   = VPN_W'(v);
        lk_asid  = ASID_W'(a);
        #1;
        chk(req, "lookup hit", int'(lk_hit), int'(exp_hit));
        if (exp_hit) chk(req, "lookup frame", int'(lk_pfn), int'(pf(v)));
        lk_valid = 1'b0;
    endtask

    task automatic fill(input int v, input int a, input bit wire_it,
                        input bit exp_rej, input int exp_slot, input string req);
        @(negedge clk);
        fill_en   = 1'b1;
        fill_vpn  = VPN_W'(v);
        fill_asid = ASID_W'(a);
        fill_pfn  = pf(v);
        fill_wire = wire_it;
        #1;
        chk(req, "fill reject", int'(fill_reject), int'(exp_rej));
        if (!exp_rej) chk(req, "fill slot", int'(fill_slot), exp_slot);
        @(negedge clk);
        fill_en   = 1'b0;
        fill_wire = 1'b0;
    endtask

    task automatic pin(input int idx, input bit set);
        @(negedge clk);
        pin_en  = 1'b1;
        pin_idx = IDX_W'(idx);
        pin_set = set;
        @(negedge clk);
        pin_en  = 1'b0;
    endtask

    task automatic flush(input bit all, input bit by_id, input int a);
        @(negedge clk);
        flush_all     = all;
        flush_asid_en = by_id;
        flush_asid    = ASID_W'(a);
        @(negedge clk);
        flush_all     = 1'b0;
        flush_asid_en = 1'b0;
    endtask

    task automatic t_reset;
        lookup('h10, 1, 1'b0, "R1");
        lookup('h0, 0, 1'b0, "R1");
        fill('h10, 1, 1'b0, 1'b0, 0, "R1");
    endtask

    task automatic t_fill_all;
        for (int i = 1; i < 15; i++) fill('h10 + i, 1, 1'b0, 1'b0, i, "R4");
        lookup('h13, 1, 1'b1, "R2");
        lookup('h10, 1, 1'b1, "R2");
        lookup('h11, 2, 1'b0, "R3");
        @(negedge clk);
        lk_valid = 1'b0;
        lk_vpn   = 'h13;
        lk_asid  = 1;
        #1;
        chk("R2", "no hit without request", int'(lk_hit), 0);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        lk_valid  = 1'b1;
        lk_vpn    = 'h1F;
        lk_asid   = 1;
        fill_en   = 1'b1;
        fill_vpn  = 'h1F;
        fill_asid = 1;
        fill_pfn  = pf('h1F);
        #1;
        chk("R11", "hit during own fill", int'(lk_hit), 0);
        chk("R11", "fill slot", int'(fill_slot), 15);
        @(negedge clk);
        fill_en = 1'b0;
        #1;
        chk("R11", "hit after fill", int'(lk_hit), 1);
        chk("R11", "frame after fill", int'(lk_pfn), int'(pf('h1F)));
        lk_valid = 1'b0;
    endtask

    task automatic t_replace;
        fill('h20, 1, 1'b0, 1'b0, 0, "R5");
        fill('h21, 1, 1'b0, 1'b0, 1, "R5");
        lookup('h10, 1, 1'b0, "R5");
        lookup('h20, 1, 1'b1, "R5");
        pin(2, 1'b1);
        fill('h22, 1, 1'b0, 1'b0, 3, "R6");
        lookup('h12, 1, 1'b1, "R7");
    endtask

    task automatic t_asid_flush;
        fill('h30, 3, 1'b0, 1'b0, 4, "R5");
        flush(1'b0, 1'b1, 3);
        lookup('h30, 3, 1'b0, "R9");
        lookup('h15, 1, 1'b1, "R9");
        fill('h31, 1, 1'b0, 1'b0, 4, "R4");
        fill('h32, 1, 1'b0, 1'b0, 5, "R5");
    endtask

    task automatic t_global_flush;
        flush(1'b1, 1'b0, 0);
        lookup('h21, 1, 1'b0, "R8");
        lookup('h1F, 1, 1'b0, "R8");
        lookup('h12, 1, 1'b1, "R8");
        @(negedge clk);
        flush_all = 1'b1;
        fill_en   = 1'b1;
        fill_vpn  = 'h70;
        fill_asid = 1;
        fill_pfn  = pf('h70);
        #1;
        chk("R10", "fill reject during flush", int'(fill_reject), 1);
        @(negedge clk);
        flush_all = 1'b0;
        fill_en   = 1'b0;
        lookup('h70, 1, 1'b0, "R10");
    endtask

    task automatic t_wire_all;
        fill('h40, 1, 1'b0, 1'b0, 0, "R4");
        pin(1, 1'b1);
        fill('h41, 1, 1'b0, 1'b0, 1, "R7");
        pin(0, 1'b1);
        pin(1, 1'b1);
        for (int k = 0; k < 13; k++) fill('h50 + k, 2, 1'b1, 1'b0, 3 + k, "R12");
        fill('h60, 1, 1'b0, 1'b1, 0, "R6");
        lookup('h60, 1, 1'b0, "R6");
        lookup('h40, 1, 1'b1, "R6");
        lookup('h50, 2, 1'b1, "R6");
        pin(1, 1'b0);
        fill('h61, 1, 1'b0, 1'b0, 1, "R7");
        lookup('h41, 1, 1'b0, "R7");
        lookup('h61, 1, 1'b1, "R7");
        flush(1'b1, 1'b0, 0);
        lookup('h5C, 2, 1'b1, "R12");
        lookup('h61, 1, 1'b0, "R8");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill_all();
        t_same_cycle();
        t_replace();
        t_asid_flush();
        t_global_flush();
        t_wire_all();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule